// File: doc/BRIEF.md
# Hybrid Carry-Skip Adder with Prefix Nucleus

This block is a purely combinational, parameterized adder. It takes two WIDTH-bit operands and a carry input and returns a WIDTH-bit sum and a carry output. The operand width is cut into equal stages of SLICE bits each. Every stage adds its own slice as though its carry input were zero. A small incrementer then folds the real stage carry into that provisional result.

Carries move from one stage to the next through inverting compound gates rather than selectors. The gates alternate between an AND-OR-invert form and an OR-AND-invert form, so the polarity of the inter-stage carry flips at every boundary. One stage in the middle of the chain is built as a Kogge-Stone prefix tree instead of a ripple chain. That middle stage is called the nucleus.

The block is meant to be dropped into a datapath wherever a single-cycle adder is needed. The carry skip keeps the long path short, and the prefix nucleus shortens the middle of the chain.

Top module: `skip_prefix_adder`

## Requirements
- R1: For every input combination, the concatenation {carry_out, sum} equals op_a + op_b + carry_in taken as an unsigned (WIDTH+1)-bit value.
- R2: The carry crossing each stage boundary, into bit k*SLICE for k = 1..WIDTH/SLICE, equals the arithmetic carry into that bit position of the full addition.
- R3: Stage k (counting from 0 at the least significant end) uses an AND-OR-invert skip gate when k is even and an OR-AND-invert gate when k is odd. The link leaving an even stage therefore carries the inverted carry, and the link leaving an odd stage carries the true carry. The stage count is even, so carry_out is delivered in true polarity.
- R4: When every bit of a stage has op_a[i] XOR op_b[i] = 1, the carry leaving that stage equals the carry entering it.
- R5: Each stage's sum bits equal its zero-carry slice sum plus the true incoming stage carry, modulo 2^SLICE. In particular, a slice whose zero-carry sum is all ones wraps to all zeros when a carry arrives.
- R6: The nucleus is stage index (WIDTH/SLICE)/2 and is computed with a Kogge-Stone prefix tree of log2(SLICE) levels. Its sum bits equal the arithmetic sum bits at those positions.
- R7: With op_a = 0 and op_b = 0, sum equals carry_in zero-extended and carry_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit, true polarity |

## Verification
Within a single evaluation, a stage can both produce a carry of its own and be asked to pass a carry through from below. The skip gate has to pick the right source, and the incrementer has to apply the true carry after a polarity flip. These cases are provoked by sweeping every operand pair and carry input of an 8-bit, 2-bit-slice configuration. That sweep covers all mixes of generate, propagate and kill in every stage, including the nucleus. Directed 32-bit patterns add whole-word propagate runs, generate-then-propagate chains and a carry aimed at the nucleus, all judged against an arithmetic sum computed in the bench.

// File: rtl/skip_prefix_adder_pkg.sv
// Shared definitions for the hybrid carry-skip adder.
// Assumes nothing beyond IEEE 1800-2017 packages.
package skip_prefix_adder_pkg;

    // Kind of inverting compound gate that forms a stage's outgoing link.
    typedef enum logic {
        GATE_AOI = 1'b0,
        GATE_OAI = 1'b1
    } skip_gate_e;

    // Even stages use AND-OR-invert, odd stages use OR-AND-invert.
    function automatic skip_gate_e gate_for_stage(input int idx);
        return (idx % 2 == 0) ? GATE_AOI : GATE_OAI;
    endfunction

endpackage

// File: rtl/skip_prefix_adder_ripple.sv
// Ripple slice: adds one SLICE-bit slice with an assumed carry-in of zero.
// Returns the provisional sum, the zero-carry carry-out and the AND of all
// propagate bits. Assumes SLICE >= 1.
module skip_prefix_adder_ripple #(
    parameter int SLICE = 4
) (
    input  logic [SLICE-1:0] a_sl,
    input  logic [SLICE-1:0] b_sl,
    output logic [SLICE-1:0] sum_z,
    output logic             gen_z,
    output logic             prop_all
);

    logic [SLICE-1:0] prop;
    logic [SLICE-1:0] gen;

    // Per-bit propagate and generate terms.
    assign prop = a_sl ^ b_sl;
    assign gen  = a_sl & b_sl;

    // Ripple the carry from zero through the slice.
    always_comb begin
        logic run;
        run = 1'b0;
        for (int i = 0; i < SLICE; i++) begin
            sum_z[i] = prop[i] ^ run;
            run      = gen[i] | (prop[i] & run);
        end
        gen_z = run;
    end

    // Group propagate: every bit of the slice passes a carry.
    assign prop_all = &prop;

endmodule

// File: rtl/skip_prefix_adder_prefix.sv
// Kogge-Stone slice: adds one SLICE-bit slice with an assumed carry-in of
// zero, using log2(SLICE) prefix levels whose span doubles per level.
// Assumes SLICE is a power of two and at least 2.
module skip_prefix_adder_prefix #(
    parameter int SLICE = 4
) (
    input  logic [SLICE-1:0] a_sl,
    input  logic [SLICE-1:0] b_sl,
    output logic [SLICE-1:0] sum_z,
    output logic             gen_z,
    output logic             prop_all
);

    localparam int LEVELS = $clog2(SLICE);

    logic [SLICE-1:0]             prop;
    logic [LEVELS:0][SLICE-1:0]   grp_g;
    logic [LEVELS:0][SLICE-1:0]   grp_p;

    // Pre-processing: per-bit propagate and generate.
    assign prop = a_sl ^ b_sl;

    // Prefix tree: combine each node with the node one span below it.
    always_comb begin
        grp_g[0] = a_sl & b_sl;
        grp_p[0] = prop;
        for (int lv = 1; lv <= LEVELS; lv++) begin
            for (int i = 0; i < SLICE; i++) begin
                if (i >= (1 << (lv - 1))) begin
                    grp_g[lv][i] = grp_g[lv-1][i]
                                 | (grp_p[lv-1][i] & grp_g[lv-1][i - (1 << (lv - 1))]);
                    grp_p[lv][i] = grp_p[lv-1][i] & grp_p[lv-1][i - (1 << (lv - 1))];
                end else begin
                    grp_g[lv][i] = grp_g[lv-1][i];
                    grp_p[lv][i] = grp_p[lv-1][i];
                end
            end
        end
    end

    // Post-processing: sum bit is propagate XOR carry from the bit below.
    always_comb begin
        sum_z[0] = prop[0];
        for (int i = 1; i < SLICE; i++) begin
            sum_z[i] = prop[i] ^ grp_g[LEVELS][i-1];
        end
    end

    // Zero-carry carry-out and group propagate taken from the top node.
    assign gen_z    = grp_g[LEVELS][SLICE-1];
    assign prop_all = grp_p[LEVELS][SLICE-1];

endmodule

// File: rtl/skip_prefix_adder_inc.sv
// Incrementer: adds a single true carry bit to a SLICE-bit provisional sum.
// The carry out of the increment is not needed and is not produced.
module skip_prefix_adder_inc #(
    parameter int SLICE = 4
) (
    input  logic [SLICE-1:0] val,
    input  logic             inc,
    output logic [SLICE-1:0] result
);

    // Flip each bit while every lower bit and the increment are all ones.
    always_comb begin
        logic run;
        run = inc;
        for (int i = 0; i < SLICE; i++) begin
            result[i] = val[i] ^ run;
            run       = run & val[i];
        end
    end

endmodule

// File: rtl/skip_prefix_adder_stage.sv
// One adder stage: a zero-carry slice adder (ripple or prefix), an
// incrementer fed with the true incoming carry, and an inverting skip gate.
// An AOI stage receives its link in true polarity; an OAI stage receives it
// inverted and restores it locally before the incrementer.
module skip_prefix_adder_stage
    import skip_prefix_adder_pkg::*;
#(
    parameter int         SLICE      = 4,
    parameter bit         USE_PREFIX = 1'b0,
    parameter skip_gate_e GATE       = GATE_AOI
) (
    input  logic [SLICE-1:0] a_sl,
    input  logic [SLICE-1:0] b_sl,
    input  logic             link_in,
    output logic [SLICE-1:0] sum_sl,
    output logic             link_out
);

    logic [SLICE-1:0] sum_z;
    logic             gen_z;
    logic             prop_all;
    logic             carry_true;

    // Slice adder variant selected by parameter.
    generate
        if (USE_PREFIX) begin : g_prefix
            skip_prefix_adder_prefix #(.SLICE(SLICE)) u_add (
                .a_sl     (a_sl),
                .b_sl     (b_sl),
                .sum_z    (sum_z),
                .gen_z    (gen_z),
                .prop_all (prop_all)
            );
        end else begin : g_ripple
            skip_prefix_adder_ripple #(.SLICE(SLICE)) u_add (
                .a_sl     (a_sl),
                .b_sl     (b_sl),
                .sum_z    (sum_z),
                .gen_z    (gen_z),
                .prop_all (prop_all)
            );
        end
    endgenerate

    // Skip gate variant and local polarity restoration.
    generate
        if (GATE == GATE_AOI) begin : g_aoi
            // Incoming link is true; output is inverted carry.
            assign carry_true = link_in;
            assign link_out   = ~(gen_z | (prop_all & link_in));
        end else begin : g_oai
            // Incoming link is inverted; output is true carry.
            assign carry_true = ~link_in;
            assign link_out   = ~((~prop_all | link_in) & ~gen_z);
        end
    endgenerate

    // Fold the true incoming carry into the provisional sum.
    skip_prefix_adder_inc #(.SLICE(SLICE)) u_inc (
        .val    (sum_z),
        .inc    (carry_true),
        .result (sum_sl)
    );

endmodule

// File: rtl/skip_prefix_adder.sv
// Top of the hybrid carry-skip adder. Purely combinational.
// Assumes WIDTH is a multiple of SLICE, SLICE is a power of two >= 2 and
// the stage count WIDTH/SLICE is even, so the last gate is OR-AND-invert
// and carry_out leaves in true polarity.
module skip_prefix_adder
    import skip_prefix_adder_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SLICE = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    localparam int NSTAGE  = WIDTH / SLICE;
    localparam int NUCLEUS = NSTAGE / 2;

    // link[k] enters stage k; odd-indexed links carry inverted polarity.
    logic [NSTAGE:0] link;

    // Bit 0 receives the external carry in true polarity.
    assign link[0] = carry_in;

    // Chain of stages, the middle one built as a prefix tree.
    generate
        for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
            skip_prefix_adder_stage #(
                .SLICE      (SLICE),
                .USE_PREFIX (k == NUCLEUS),
                .GATE       (gate_for_stage(k))
            ) u_stage (
                .a_sl     (op_a[k*SLICE +: SLICE]),
                .b_sl     (op_b[k*SLICE +: SLICE]),
                .link_in  (link[k]),
                .sum_sl   (sum[k*SLICE +: SLICE]),
                .link_out (link[k+1])
            );
        end
    endgenerate

    // Final gate is OR-AND-invert, so the last link is already true.
    assign carry_out = link[NSTAGE];

endmodule

// File: rtl/skip_prefix_adder_chk.sv
// Checker for skip_prefix_adder: compares ports and inter-stage links
// against arithmetic expectations. Attached by bind below.
module skip_prefix_adder_chk #(
    parameter int WIDTH = 32,
    parameter int SLICE = 4
) (
    input logic [WIDTH-1:0]         op_a,
    input logic [WIDTH-1:0]         op_b,
    input logic                     carry_in,
    input logic [WIDTH-1:0]         sum,
    input logic                     carry_out,
    input logic [WIDTH/SLICE:0]     link
);

    localparam int NSTAGE  = WIDTH / SLICE;
    localparam int NUCLEUS = NSTAGE / 2;

    logic [WIDTH:0] full;
    logic [WIDTH:0] carry_at;

    // Reference addition and the carry into every bit position.
    always_comb begin
        full = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        for (int j = 0; j < WIDTH; j++) begin
            carry_at[j] = full[j] ^ op_a[j] ^ op_b[j];
        end
        carry_at[WIDTH] = full[WIDTH];
    end

    // Port-level and link-level checks.
    always_comb begin
        a_r1_sum_exact: assert ({carry_out, sum} == full);
        for (int k = 1; k <= NSTAGE; k++) begin
            // R2 and R3: decoded link equals arithmetic carry, polarity by stage.
            a_r3_link_polarity: assert (link[k] == (carry_at[k*SLICE] ^ k[0]));
            if (&(op_a[(k-1)*SLICE +: SLICE] ^ op_b[(k-1)*SLICE +: SLICE])) begin
                a_r4_skip_pass: assert ((link[k] ^ k[0]) == (link[k-1] ^ ((k - 1) % 2 == 1)));
            end
        end
        a_r6_nucleus_bits: assert (sum[NUCLEUS*SLICE +: SLICE] == full[NUCLEUS*SLICE +: SLICE]);
        if (op_a == '0 && op_b == '0) begin
            a_r7_zero_operands: assert (sum == {{(WIDTH-1){1'b0}}, carry_in} && !carry_out);
        end
    end

endmodule

bind skip_prefix_adder skip_prefix_adder_chk #(
    .WIDTH (WIDTH),
    .SLICE (SLICE)
) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out),
    .link      (link)
);

// File: tb/skip_prefix_adder_test.sv
// Bench: exhaustive sweep at WIDTH=8/SLICE=2, random and directed vectors
// at WIDTH=32/SLICE=4, all judged against an arithmetic sum.
module skip_prefix_adder_test;

    logic clk = 1'b0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    logic [7:0]  a8, b8, s8;
    logic        c8, co8;
    logic [31:0] a32, b32, s32;
    logic        c32, co32;

    // 125 MHz clock.
    always #4 clk = ~clk;

    skip_prefix_adder #(.WIDTH(8), .SLICE(2)) uut (
        .op_a (a8), .op_b (b8), .carry_in (c8), .sum (s8), .carry_out (co8)
    );

    skip_prefix_adder #(.WIDTH(32), .SLICE(4)) uut_wide (
        .op_a (a32), .op_b (b32), .carry_in (c32), .sum (s32), .carry_out (co32)
    );

    // Drive one narrow vector and compare at the following falling edge.
    task automatic check8(input logic [7:0] a, input logic [7:0] b, input logic c,
                          input string tag);
        logic [8:0] exp;
        @(posedge clk);
        a8 = a; b8 = b; c8 = c;
        @(negedge clk);
        exp = {1'b0, a} + {1'b0, b} + {8'd0, c};
        n_checks++;
        if ({co8, s8} !== exp) begin
            n_errors++;
            $display("FAIL %s a=%h b=%h c=%0d got=%h exp=%h", tag, a, b, c, {co8, s8}, exp);
        end
    endtask

    // Drive one wide vector and compare at the following falling edge.
    task automatic check32(input logic [31:0] a, input logic [31:0] b, input logic c,
                           input string tag);
        logic [32:0] exp;
        @(posedge clk);
        a32 = a; b32 = b; c32 = c;
        @(negedge clk);
        exp = {1'b0, a} + {1'b0, b} + {32'd0, c};
        n_checks++;
        if ({co32, s32} !== exp) begin
            n_errors++;
            $display("FAIL %s a=%h b=%h c=%0d got=%h exp=%h", tag, a, b, c, {co32, s32}, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        a8 = '0; b8 = '0; c8 = 1'b0;
        a32 = '0; b32 = '0; c32 = 1'b0;

        // R7: zero operands, idle state at start.
        check32(32'h0, 32'h0, 1'b0, "R7 zero+zero cin0");
        check32(32'h0, 32'h0, 1'b1, "R7 zero+zero cin1");

        // R4/R3: whole word propagates, carry_out follows carry_in.
        check32(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R4 R3 all-propagate cin0");
        check32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R4 R3 all-propagate cin1");

        // R5/R2: every slice wraps, carry crosses every boundary.
        check32(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R5 R2 all-ones plus one");
        check32(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R5 R2 all-ones plus carry");
        check32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R1 R3 max operands");

        // R4: low stage generates, all higher stages propagate.
        check32(32'hAAAA_AAAF, 32'h5555_5551, 1'b0, "R4 generate then skip");

        // R6: carry generated just below the nucleus and inside it.
        check32(32'h0000_F000, 32'h0000_1000, 1'b0, "R6 carry into nucleus");
        check32(32'h000F_0000, 32'h0001_0000, 1'b0, "R6 carry out of nucleus");
        check32(32'h0005_0000, 32'h000A_F000, 1'b0, "R6 nucleus propagates");
        check32(32'h0003_0000, 32'h0001_0000, 1'b1, "R6 nucleus internal carry");

        // R1: random wide vectors.
        for (int i = 0; i < 2000; i++) begin
            check32($urandom, $urandom, 1'($urandom), "R1 random wide");
        end

        // R1 R2 R3 R4 R5 R6: exhaustive narrow sweep.
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                for (int c = 0; c < 2; c++) begin
                    check8(8'(a), 8'(b), 1'(c), "R1 exhaustive narrow");
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule